// File: doc/BRIEF.md
# DMA Channel Interrupt Flag Logic

This block keeps the sticky event flags of a small multi-channel DMA engine and produces one interrupt line per channel. Each channel's transfer engine sends three kinds of single-cycle pulses: a whole transfer finished, half of a transfer finished, and a transfer failed. Each pulse sets a sticky flag. A per-channel summary flag is set whenever any of the three is recorded. An interrupt output per channel is the summary flag gated by an external enable input.

Software sees the flags through a simple register bus. A read-only status word sits at offset 0x00. A write-one-to-clear register sits at offset 0x04 and uses the same bit layout. The summary flag can be cleared in two ways. The channel's summary-clear bit wipes all four flags. An individual clear bit drops the summary flag only when, after the clear, none of the channel's three event flags remains set. An event pulse that meets a clear of the same flag in the same cycle wins, so no event is lost.

Top module: `dma_irq_flags`

## Requirements
- R1: After reset, the status word reads 0 and every irq output is 0.
- R2: Channel c (0-based) uses status bits 4c to 4c+3: bit 4c is the summary flag, 4c+1 transfer-complete, 4c+2 half-transfer, 4c+3 transfer-error. Status bits at 4*NUM_CH and above read 0.
- R3: A pulse on ev_done, ev_half or ev_err of a channel sets the matching flag and the channel's summary flag on the next clock edge. The summary flag always equals the OR of the three event flags.
- R4: Writing offset 0x04 with bit 4c set clears all four flags of channel c.
- R5: Writing offset 0x04 with bit 4c+1, 4c+2 or 4c+3 set clears the matching event flag. It also clears the summary flag only if the channel's remaining event flags are both 0 after that write.
- R6: An event pulse in the same cycle as a clear of the same flag leaves that flag and the summary flag set.
- R7: Clear-register bits written as 0 change nothing; a channel whose nibble is written as 0 keeps its flags.
- R8: Writes to the status offset or to any offset other than 0x04 leave every flag unchanged.
- R9: Reads of offset 0x04 and of unmapped offsets return 0. bus_rdata is combinational from bus_addr.
- R10: irq[c] is high exactly when channel c's summary flag is set and irq_en[c] is high; irq_en acts without a clock delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| ev_done | input | NUM_CH | Transfer-complete pulses, one per channel |
| ev_half | input | NUM_CH | Half-transfer pulses, one per channel |
| ev_err | input | NUM_CH | Transfer-error pulses, one per channel |
| irq_en | input | NUM_CH | Interrupt enable per channel |
| irq | output | NUM_CH | Interrupt request per channel |

## Verification
On every cycle the assertions check that each summary flag matches the OR of its event flags. They also check that an event pulse survives a clear in the same cycle, that a summary-clear empties a quiet channel, that zero nibbles and writes to other offsets change nothing, and that the clear offset reads as zero. The exact summary-flag result of individual clears depends on the other flags of the channel, so only the bench's scenarios can show it. The same holds for the bit positions of each channel in the status word and the gating of irq by the enables. The bench covers these with directed cases and a long random mix of events and clears, compared against a reference model.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
    localparam int DATA_W       = 32;
    localparam int FLAGS_PER_CH = 4;
    localparam int MAX_CH       = DATA_W / FLAGS_PER_CH;

    // bit positions inside one channel nibble
    localparam int BIT_SUM  = 0;
    localparam int BIT_DONE = 1;
    localparam int BIT_HALF = 2;
    localparam int BIT_ERR  = 3;

    localparam logic [7:0] OFS_STATUS = 8'h00;
    localparam logic [7:0] OFS_CLEAR  = 8'h04;

    typedef struct packed {
        logic err;
        logic half;
        logic done;
        logic sum;
    } ch_flags_t;
endpackage

// File: rtl/dma_irq_clr_decode.sv
module dma_irq_clr_decode
    import dma_irq_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic                           bus_wr,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [NUM_CH*FLAGS_PER_CH-1:0] wdata_lo,
    output logic [NUM_CH*FLAGS_PER_CH-1:0] clr_strobe
);
    logic hit;

    always_comb begin
        hit        = bus_wr && (bus_addr == ADDR_W'(OFS_CLEAR));
        clr_strobe = hit ? wdata_lo : '0;
    end
endmodule

// File: rtl/dma_irq_channel.sv
module dma_irq_channel
    import dma_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_done,
    input  logic       ev_half,
    input  logic       ev_err,
    input  logic [3:0] clr,
    input  logic       irq_en,
    output ch_flags_t  flags,
    output logic       irq
);
    ch_flags_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // clears first
        if (clr[BIT_SUM]) begin
            st_d = '0;
        end
        if (clr[BIT_DONE]) st_d.done = 1'b0;
        if (clr[BIT_HALF]) st_d.half = 1'b0;
        if (clr[BIT_ERR])  st_d.err  = 1'b0;
        if ((|clr[BIT_ERR:BIT_DONE]) && !(st_d.done || st_d.half || st_d.err)) begin
            st_d.sum = 1'b0;
        end
        // events take priority over any clear in the same cycle
        if (ev_done) st_d.done = 1'b1;
        if (ev_half) st_d.half = 1'b1;
        if (ev_err)  st_d.err  = 1'b1;
        if (ev_done || ev_half || ev_err) st_d.sum = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        flags = st_q;
        irq   = st_q.sum & irq_en;
    end
endmodule

// File: rtl/dma_irq_read_mux.sv
module dma_irq_read_mux
    import dma_irq_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [NUM_CH*FLAGS_PER_CH-1:0] status,
    output logic [DATA_W-1:0]              rdata
);
    logic [DATA_W-1:0] status_ext;

    always_comb begin
        status_ext = '0;
        status_ext[NUM_CH*FLAGS_PER_CH-1:0] = status;
        rdata = (bus_addr == ADDR_W'(OFS_STATUS)) ? status_ext : '0;
    end
endmodule

// File: rtl/dma_irq_flags.sv
module dma_irq_flags
    import dma_irq_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NUM_CH-1:0] ev_done,
    input  logic [NUM_CH-1:0] ev_half,
    input  logic [NUM_CH-1:0] ev_err,
    input  logic [NUM_CH-1:0] irq_en,
    output logic [NUM_CH-1:0] irq
);
    localparam int STAT_W = NUM_CH * FLAGS_PER_CH;

    initial begin
        if (NUM_CH < 1 || NUM_CH > MAX_CH) $error("NUM_CH out of range");
    end

    logic [STAT_W-1:0] clr_strobe;
    logic [STAT_W-1:0] status_flat;

    dma_irq_clr_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_decode (
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .wdata_lo   (bus_wdata[STAT_W-1:0]),
        .clr_strobe (clr_strobe)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        ch_flags_t ch_flags;

        dma_irq_channel u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .ev_done (ev_done[c]),
            .ev_half (ev_half[c]),
            .ev_err  (ev_err[c]),
            .clr     (clr_strobe[c*FLAGS_PER_CH +: FLAGS_PER_CH]),
            .irq_en  (irq_en[c]),
            .flags   (ch_flags),
            .irq     (irq[c])
        );

        assign status_flat[c*FLAGS_PER_CH +: FLAGS_PER_CH] = ch_flags;
    end

    dma_irq_read_mux #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_rmux (
        .bus_addr (bus_addr),
        .status   (status_flat),
        .rdata    (bus_rdata)
    );
endmodule

// File: rtl/dma_irq_flags_chk.sv
module dma_irq_flags_chk
    import dma_irq_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           bus_wr,
    input logic [ADDR_W-1:0]              bus_addr,
    input logic [31:0]                    bus_wdata,
    input logic [31:0]                    bus_rdata,
    input logic [NUM_CH-1:0]              ev_done,
    input logic [NUM_CH-1:0]              ev_half,
    input logic [NUM_CH-1:0]              ev_err,
    input logic [NUM_CH*FLAGS_PER_CH-1:0] stat
);
    logic clr_wr;
    logic any_ev;
    assign clr_wr = bus_wr && (bus_addr == ADDR_W'(OFS_CLEAR));
    assign any_ev = |{ev_done, ev_half, ev_err};

    // R8: writes anywhere but the clear offset leave all flags alone
    assert_other_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !clr_wr && !any_ev) |=> $stable(stat));

    // R9: the clear offset reads as zero
    assert_clr_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFS_CLEAR)) |-> (bus_rdata == 32'h0));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        localparam int B = c * FLAGS_PER_CH;
        logic ch_ev;
        assign ch_ev = ev_done[c] | ev_half[c] | ev_err[c];

        // R3: summary flag tracks the OR of the event flags
        assert_sum_is_or_R3: assert property (@(posedge clk) disable iff (!rst_n)
            stat[B+BIT_SUM] == (stat[B+BIT_DONE] | stat[B+BIT_HALF] | stat[B+BIT_ERR]));

        // R6: an event wins over any clear in the same cycle
        assert_evt_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
            ev_err[c] |=> (stat[B+BIT_ERR] && stat[B+BIT_SUM]));

        // R4: summary clear empties a quiet channel
        assert_sum_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_wr && bus_wdata[B+BIT_SUM] && !ch_ev) |=> (stat[B +: FLAGS_PER_CH] == 4'h0));

        // R7: a zero nibble in a clear write changes nothing
        assert_zero_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_wr && (bus_wdata[B +: FLAGS_PER_CH] == 4'h0) && !ch_ev)
            |=> $stable(stat[B +: FLAGS_PER_CH]));
    end
endmodule

bind dma_irq_flags dma_irq_flags_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ev_done   (ev_done),
    .ev_half   (ev_half),
    .ev_err    (ev_err),
    .stat      (status_flat)
);

// File: tb/tb_dma_irq_flags.sv
module tb_dma_irq_flags;
    localparam int N = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_addr = 8'h00;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  ev_done = '0, ev_half = '0, ev_err = '0, irq_en = '0;
    logic [N-1:0]  irq;

    int checks = 0;
    int fails  = 0;
    logic [3:0] m [N];

    always #5 clk = ~clk;

    dma_irq_flags #(.NUM_CH(N), .ADDR_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_done(ev_done),
        .ev_half(ev_half), .ev_err(ev_err), .irq_en(irq_en), .irq(irq)
    );

    // reference: nibble {err, half, done, sum}
    function automatic logic [3:0] ref_next(input logic [3:0] cur, input logic [3:0] clr,
                                            input logic d_ev, input logic h_ev, input logic e_ev);
        logic s, d, h, e;
        s = cur[0]; d = cur[1]; h = cur[2]; e = cur[3];
        if (clr[0]) begin s = 0; d = 0; h = 0; e = 0; end
        if (clr[1]) d = 0;
        if (clr[2]) h = 0;
        if (clr[3]) e = 0;
        if ((|clr[3:1]) && !(d | h | e)) s = 0;
        if (d_ev) d = 1;
        if (h_ev) h = 1;
        if (e_ev) e = 1;
        if (d_ev | h_ev | e_ev) s = 1;
        return {e, h, d, s};
    endfunction

    function automatic logic [31:0] ref_status();
        logic [31:0] v = '0;
        for (int c = 0; c < N; c++) v[4*c +: 4] = m[c];
        return v;
    endfunction

    function automatic logic [N-1:0] ref_irq();
        logic [N-1:0] v;
        for (int c = 0; c < N; c++) v[c] = m[c][0] & irq_en[c];
        return v;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // called at a negedge; applies one cycle of stimulus and checks the result
    task automatic step(input string tag, input logic wr, input logic [7:0] a,
                        input logic [31:0] wd, input logic [N-1:0] ed,
                        input logic [N-1:0] eh, input logic [N-1:0] ee);
        bus_wr = wr; bus_addr = a; bus_wdata = wd;
        ev_done = ed; ev_half = eh; ev_err = ee;
        @(posedge clk);
        for (int c = 0; c < N; c++)
            m[c] = ref_next(m[c], (wr && a == 8'h04) ? wd[4*c +: 4] : 4'h0, ed[c], eh[c], ee[c]);
        @(negedge clk);
        bus_wr = 0; bus_addr = 8'h00; bus_wdata = '0;
        ev_done = '0; ev_half = '0; ev_err = '0;
        #1;
        chk({tag, " status"}, bus_rdata, ref_status());
        chk({tag, " irq R10"}, 32'(irq), 32'(ref_irq()));
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] seed_dummy;
        for (int c = 0; c < N; c++) m[c] = 4'h0;
        seed_dummy = $urandom(32'h5eed_1234);
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset status", bus_rdata, 32'h0);
        chk("R1 reset irq", 32'(irq), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        irq_en = '1;

        // R2: done on channel 2 lands at bits 9 and 8
        step("R2 R3 layout", 0, 8'h00, 0, 4'b0100, 0, 0);
        chk("R2 literal", bus_rdata, 32'h0000_0300);
        // R5: clear done while err set keeps summary
        step("R3 err ch2", 0, 8'h00, 0, 0, 0, 4'b0100);
        step("R5 clear done", 1, 8'h04, 32'h0000_0200, 0, 0, 0);
        chk("R5 sum kept", bus_rdata, 32'h0000_0900);
        step("R5 clear err", 1, 8'h04, 32'h0000_0800, 0, 0, 0);
        chk("R5 sum dropped", bus_rdata, 32'h0);
        // R5: both remaining flags cleared together drop the summary
        step("R3 half+done ch1", 0, 8'h00, 0, 4'b0010, 4'b0010, 0);
        step("R5 joint clear", 1, 8'h04, 32'h0000_0060, 0, 0, 0);
        chk("R5 joint literal", bus_rdata, 32'h0);
        // R4: summary clear wipes all
        step("R3 all ch0", 0, 8'h00, 0, 4'b0001, 4'b0001, 4'b0001);
        step("R4 sum clear", 1, 8'h04, 32'h0000_0001, 0, 0, 0);
        chk("R4 literal", bus_rdata, 32'h0);
        // R6: event colliding with clear
        step("R6 collide", 1, 8'h04, 32'h0000_F000, 0, 4'b1000, 0);
        chk("R6 literal", bus_rdata, 32'h0000_5000);
        // R7: zero nibbles
        step("R7 zero write", 1, 8'h04, 32'h0000_0000, 0, 0, 0);
        // R8: writes to status and unmapped offsets
        step("R8 status write", 1, 8'h00, 32'hFFFF_FFFF, 0, 0, 0);
        step("R8 other write", 1, 8'h08, 32'hFFFF_FFFF, 0, 0, 0);
        chk("R8 literal", bus_rdata, 32'h0000_5000);
        // R9: read-back of clear and unmapped offsets
        bus_addr = 8'h04; #1;
        chk("R9 clear reads 0", bus_rdata, 32'h0);
        bus_addr = 8'h08; #1;
        chk("R9 unmapped reads 0", bus_rdata, 32'h0);
        bus_addr = 8'h00; #1;
        // R10: enable gating acts at once
        irq_en = 4'b0111; #1;
        chk("R10 gated off", 32'(irq), 32'h0);
        irq_en = 4'b1000; #1;
        chk("R10 gated on", 32'(irq), 32'h8);
        // R2: upper bits stay 0 even with everything set
        step("R2 fill", 0, 8'h00, 0, '1, '1, '1);
        chk("R2 upper zero", {16'h0, bus_rdata[31:16]}, 32'h0);

        // random mix
        for (int i = 0; i < 1500; i++) begin
            logic [7:0] a;
            logic [1:0] sel = 2'($urandom_range(0, 3));
            a = (sel == 0) ? 8'h00 : (sel == 3) ? 8'h08 : 8'h04;
            irq_en = N'($urandom);
            step("R3 R4 R5 R6 R7 random", 1'($urandom), a, $urandom,
                 N'($urandom) & N'($urandom), N'($urandom) & N'($urandom),
                 N'($urandom) & N'($urandom) & N'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule